// File: doc/BRIEF.md
# SMBus Target Byte Engine

This block is the protocol core of a serial-bus target. It answers one fixed 7-bit address. A fast system clock oversamples the bus clock and data lines. The core finds START and STOP conditions, collects the address byte, and acknowledges only its own address. After that it moves data bytes in either direction through a small byte port. On the write side it presents each received byte with a one-cycle strobe. On the read side it takes the next byte to send from a presented value and pulses a strobe when it has taken that byte.

Packet error checking is optional. The core keeps a running CRC-8 over every byte of a transaction, and the address bytes are included in it. On writes it flags each received byte that equals the CRC of everything before it, so the register side can recognise a valid trailing check byte. On reads, the register side marks the final data byte. If the master acknowledges that byte and clocks one more, the core sends the CRC as that extra byte.

A bus-inactivity timeout is available. When it is enabled, a bus that stays silent for a set number of system clocks returns the core to idle and frees the data line. The data output is an open-drain pull-down enable.

Top module: `smbus_target`

## Requirements
- R1: After reset, sda_oe is 0, wr_stb and rd_stb are 0, the engine is idle, and the timeout takes effect only when timeout_en is high.
- R2: A falling SDA while SCL is high (START) begins address reception. A rising SDA while SCL is high (STOP) returns the engine to idle with SDA released, so that bytes clocked after a STOP without a new START are not acknowledged.
- R3: The first byte after START is a 7-bit address, MSB first, followed by the R/W bit (0 = master write, 1 = master read). Only address 7'h4C is acknowledged, by pulling SDA low during the ninth clock. Any other address is not acknowledged, and all later bytes are ignored until the next START.
- R4: In a write, each data byte is shifted in MSB first and acknowledged on its ninth clock. It appears on wr_byte with a single-cycle wr_stb, and wr_first is high only for the first data byte after the address.
- R5: In a read, the engine takes rd_byte and shifts it out MSB first, pulsing rd_stb once for each byte taken. A master ACK (SDA low on the ninth clock) makes it take the next byte.
- R6: The engine changes its SDA drive only while SCL is low, so the line is stable during every SCL high phase.
- R7: wr_pec_ok is high with wr_stb exactly when the received byte equals the CRC-8 (polynomial x^8+x^2+x+1, i.e. 0x07, initial value 0x00, MSB first) of all earlier bytes of the transaction, address bytes included.
- R8: If the master ACKs a read byte that was taken while rd_last was high and clocks one more byte, the engine sends the CRC-8 of all transaction bytes so far as that byte, without pulsing rd_stb.
- R9: The CRC restarts at 0x00 on a START that follows a STOP or idle. A repeated START inside a transaction keeps accumulating.
- R10: A master NACK on a read byte ends the data phase. SDA stays released (extra clocked bytes read 0xFF) and rd_stb stays low until the next START or STOP.
- R11: With timeout_en high, TIMEOUT_CYCLES system clocks without any change on SCL or SDA return the engine to idle with SDA released. With timeout_en low, a bus stall of any length has no effect.
- R12: wr_stb and rd_stb are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| timeout_en | input | 1 | Enables the bus-inactivity timeout |
| rd_byte | input | 8 | Next byte to send on a read |
| rd_last | input | 1 | Marks rd_byte as the final data byte |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wr_stb | output | 1 | One-cycle strobe for a received write byte |
| wr_byte | output | 8 | Received write byte |
| wr_first | output | 1 | Byte is the first one after the address |
| wr_pec_ok | output | 1 | Byte equals the CRC of the earlier bytes |
| rd_stb | output | 1 | rd_byte was taken; present the next one |

## Verification
The address byte is swept over all 128 values with a trailing data byte. This shows that only 7'h4C is acknowledged and that a rejected address also silences the rest of the transaction. Write data uses all-zero, all-one, alternating and single-bit patterns, which tell bit-order errors and stuck bits apart, and the check-byte flag is compared with a CRC computed in the bench. Reads of different lengths end either in a NACK or in a PEC byte. Two back-to-back transactions separate a CRC that restarts at START from one that carries over, and a repeated START inside a read tells whether the address bytes are included. Identical bus stalls with the timeout enabled and disabled show that the timeout alone causes the return to idle.

// File: rtl/smbus_target.sv
module smbus_target #(
  parameter logic [6:0] DEV_ADDR       = 7'h4C,
  parameter int         TIMEOUT_CYCLES = 2_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       timeout_en,
  input  logic [7:0] rd_byte,
  input  logic       rd_last,
  output logic       sda_oe,
  output logic       wr_stb,
  output logic [7:0] wr_byte,
  output logic       wr_first,
  output logic       wr_pec_ok,
  output logic       rd_stb
);
  localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} st_t;

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ({r[6:0], 1'b0} ^ 8'h07) : {r[6:0], 1'b0};
    return r;
  endfunction

  logic [1:0] scl_m, sda_m;
  logic scl_s, sda_s, scl_q, sda_q;
  st_t state;
  logic [3:0] cnt;
  logic [7:0] sh, txb, crc;
  logic rw, first, last, pec_done, mack, in_txn;
  logic [TO_W-1:0] to_cnt;

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire quiet     = (scl_s == scl_q) && (sda_s == sda_q);
  wire tmo_hit   = timeout_en && quiet && (to_cnt == TO_W'(TIMEOUT_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 2'b11;
      sda_m <= 2'b11;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      to_cnt <= '0;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
      if (!timeout_en || !quiet) to_cnt <= '0;
      else if (to_cnt != TO_W'(TIMEOUT_CYCLES)) to_cnt <= to_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt <= '0;
      sh <= '0;
      txb <= '0;
      crc <= '0;
      rw <= 1'b0;
      first <= 1'b0;
      last <= 1'b0;
      pec_done <= 1'b0;
      mack <= 1'b0;
      in_txn <= 1'b0;
      sda_oe <= 1'b0;
      wr_stb <= 1'b0;
      wr_byte <= '0;
      wr_first <= 1'b0;
      wr_pec_ok <= 1'b0;
      rd_stb <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      rd_stb <= 1'b0;
      if (tmo_hit) begin
        state <= S_IDLE;
        sda_oe <= 1'b0;
        in_txn <= 1'b0;
      end else if (start_det) begin
        state <= S_ADDR;
        cnt <= '0;
        sda_oe <= 1'b0;
        in_txn <= 1'b1;
        if (!in_txn) crc <= 8'h00;
      end else if (stop_det) begin
        state <= S_IDLE;
        sda_oe <= 1'b0;
        in_txn <= 1'b0;
      end else begin
        case (state)
          S_ADDR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sh[7:1] == DEV_ADDR) begin
                rw <= sh[0];
                crc <= crc8(crc, sh);
                sda_oe <= 1'b1;
                state <= S_AACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              rd_stb <= 1'b1;
              txb <= rd_byte;
              last <= rd_last;
              pec_done <= 1'b0;
              sda_oe <= ~rd_byte[7];
              state <= S_RD;
            end else begin
              sda_oe <= 1'b0;
              first <= 1'b1;
              state <= S_WR;
            end
          end
          S_WR: begin
            if (scl_rise) begin
              sh <= {sh[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              wr_stb <= 1'b1;
              wr_byte <= sh;
              wr_first <= first;
              wr_pec_ok <= (sh == crc);
              first <= 1'b0;
              crc <= crc8(crc, sh);
              sda_oe <= 1'b1;
              state <= S_WACK;
            end
          end
          S_WACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt <= '0;
            state <= S_WR;
          end
          S_RD: begin
            if (scl_rise) cnt <= cnt + 4'd1;
            else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0;
                crc <= crc8(crc, txb);
                state <= S_RACK;
              end else begin
                sda_oe <= ~txb[~cnt[2:0]];
              end
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                cnt <= '0;
                state <= S_RD;
                if (pec_done) begin
                  txb <= 8'hFF;
                  sda_oe <= 1'b0;
                end else if (last) begin
                  txb <= crc;
                  sda_oe <= ~crc[7];
                  pec_done <= 1'b1;
                end else begin
                  rd_stb <= 1'b1;
                  txb <= rd_byte;
                  last <= rd_last;
                  sda_oe <= ~rd_byte[7];
                end
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smbus_target_chk.sv
module smbus_target_chk #(
  parameter int TIMEOUT_CYCLES = 2_500_000
) (
  input logic clk,
  input logic rst_n,
  input logic timeout_en,
  input logic scl_s,
  input logic sda_s,
  input logic scl_q,
  input logic sda_q,
  input logic stop_det,
  input logic sda_oe,
  input logic wr_stb,
  input logic rd_stb
);
  logic [31:0] q_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_cnt <= '0;
    else if (!timeout_en || scl_s != scl_q || sda_s != sda_q) q_cnt <= '0;
    else if (q_cnt != 32'hFFFF_FFFF) q_cnt <= q_cnt + 1;
  end

  AST_OE_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !scl_q); // R6
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(wr_stb && rd_stb)); // R12
  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |=> !wr_stb); // R12
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_stb |=> !rd_stb); // R12
  AST_WR_ACKED: assert property (@(posedge clk) disable iff (!rst_n) wr_stb |-> sda_oe); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) stop_det |=> !sda_oe); // R2
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (q_cnt > 32'(TIMEOUT_CYCLES)) |-> !sda_oe); // R11
endmodule

bind smbus_target smbus_target_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .timeout_en(timeout_en), .scl_s(scl_s), .sda_s(sda_s),
  .scl_q(scl_q), .sda_q(sda_q), .stop_det(stop_det), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .rd_stb(rd_stb)
);

// File: tb/smbus_target_tb.sv
module smbus_target_tb;
  localparam int H  = 6;
  localparam int TO = 200;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1, ten = 1'b0;
  logic sda_oe, wr_stb, wr_first, wr_pec_ok, rd_stb;
  logic [7:0] wr_byte;
  wire sda_line = m_sda & ~sda_oe;

  logic [7:0] rsrc [0:7];
  int rcnt = 0, rbase = 0, rlen = 1;
  wire [7:0] rd_byte = rsrc[3'(rcnt - rbase)];
  wire rd_last = ((rcnt - rbase) == rlen - 1);

  logic [7:0] wlog [0:255];
  logic wf [0:255];
  logic wp [0:255];
  int wcnt = 0, bad12 = 0;
  logic wr_d = 1'b0, rd_d = 1'b0;

  int checks = 0, failures = 0;

  smbus_target #(.DEV_ADDR(7'h4C), .TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .timeout_en(ten),
    .rd_byte(rd_byte), .rd_last(rd_last), .sda_oe(sda_oe), .wr_stb(wr_stb),
    .wr_byte(wr_byte), .wr_first(wr_first), .wr_pec_ok(wr_pec_ok), .rd_stb(rd_stb)
  );

  always @(posedge clk) begin
    if (rd_stb) rcnt <= rcnt + 1;
    if (wr_stb) begin
      wlog[wcnt[7:0]] <= wr_byte;
      wf[wcnt[7:0]] <= wr_first;
      wp[wcnt[7:0]] <= wr_pec_ok;
      wcnt <= wcnt + 1;
    end
    if ((wr_stb && rd_stb) || (wr_stb && wr_d) || (rd_stb && rd_d)) bad12 <= bad12 + 1;
    wr_d <= wr_stb;
    rd_d <= rd_stb;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ d[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  task automatic clk_bit(input logic v, output logic s);
    logic early;
    m_sda = v;
    cyc(H);
    scl = 1'b1;
    cyc(1);
    early = sda_line;
    cyc(H - 1);
    s = sda_line;
    chk(early == s, "R6 sda stable in scl high", s, early);
    scl = 1'b0;
    cyc(1);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; cyc(H);
    scl = 1'b1; cyc(H);
    m_sda = 1'b0; cyc(H);
    scl = 1'b0; cyc(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; cyc(H);
    scl = 1'b1; cyc(H);
    m_sda = 1'b1; cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!ack, s);
  endtask

  task automatic rd_txn(input logic [7:0] ptr, input int n, input bit want_pec);
    logic [7:0] c, b;
    bit a;
    int rb;
    c = 8'h00;
    rbase = rcnt;
    rlen = n;
    rb = rcnt;
    bus_start();
    send_byte(8'h98, a); chk(a, "R3 read-path address ack", a, 1); c = crc_step(c, 8'h98);
    send_byte(ptr, a);   chk(a, "R4 pointer ack", a, 1);           c = crc_step(c, ptr);
    bus_start();
    send_byte(8'h99, a); chk(a, "R5 read address ack", a, 1);      c = crc_step(c, 8'h99);
    for (int i = 0; i < n; i++) begin
      recv_byte((i < n - 1) || want_pec, b);
      chk(b == rsrc[i], "R5 read data", b, rsrc[i]);
      c = crc_step(c, b);
    end
    if (want_pec) begin
      recv_byte(1'b0, b);
      chk(b == c, "R8 R9 read PEC", b, c);
    end
    chk(rcnt - rb == n, "R5 rd_stb count", rcnt - rb, n);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R10 released after NACK", b, 8'hFF);
    chk(rcnt - rb == n, "R10 no fetch after NACK", rcnt - rb, n);
    bus_stop();
  endtask

  initial begin
    logic [7:0] wd [0:5];
    logic [7:0] c;
    bit a, a2;
    int wb;
    wd[0] = 8'h00; wd[1] = 8'hFF; wd[2] = 8'hA5; wd[3] = 8'h5A; wd[4] = 8'h01; wd[5] = 8'h80;
    for (int i = 0; i < 8; i++) rsrc[i] = 8'h00;

    cyc(4);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(wr_stb == 1'b0 && rd_stb == 1'b0, "R1 reset strobes", {wr_stb, rd_stb}, 0);
    rst_n = 1'b1;
    cyc(4);
    chk(sda_oe == 1'b0, "R1 idle after reset", sda_oe, 0);

    // R3 address sweep with a trailing byte
    for (int ad = 0; ad < 128; ad++) begin
      wb = wcnt;
      bus_start();
      send_byte({ad[6:0], 1'b0}, a);
      chk(a == (ad == 'h4C), "R3 address ack", a, ad == 'h4C);
      send_byte(8'h3C, a2);
      chk(a2 == (ad == 'h4C), "R3 trailing byte ack", a2, ad == 'h4C);
      chk(wcnt - wb == ((ad == 'h4C) ? 1 : 0), "R3 write strobes", wcnt - wb, ad == 'h4C);
      bus_stop();
    end

    // R2: bytes after STOP without START are ignored
    wb = wcnt;
    send_byte(8'h98, a);
    chk(!a, "R2 no ack after STOP", a, 0);
    send_byte(8'h11, a);
    chk(!a && wcnt == wb, "R2 no write after STOP", wcnt - wb, 0);
    bus_stop();

    // R4 R7 write data patterns with a trailing check byte
    c = crc_step(8'h00, 8'h98);
    wb = wcnt;
    bus_start();
    send_byte(8'h98, a);
    chk(a, "R3 own address ack", a, 1);
    for (int i = 0; i < 6; i++) begin
      send_byte(wd[i], a);
      chk(a, "R4 data ack", a, 1);
      chk(wlog[8'(wb + i)] == wd[i], "R4 data value", wlog[8'(wb + i)], wd[i]);
      chk(wf[8'(wb + i)] == (i == 0), "R4 first flag", wf[8'(wb + i)], i == 0);
      chk(wp[8'(wb + i)] == (wd[i] == c), "R7 pec flag on data", wp[8'(wb + i)], wd[i] == c);
      c = crc_step(c, wd[i]);
    end
    send_byte(c, a);
    chk(wp[8'(wb + 6)] == 1'b1, "R7 pec flag on check byte", wp[8'(wb + 6)], 1);
    c = crc_step(c, c);
    send_byte(8'h5F, a);
    chk(wp[8'(wb + 7)] == (8'h5F == c), "R7 pec flag on bad byte", wp[8'(wb + 7)], 8'h5F == c);
    chk(wcnt - wb == 8, "R4 write count", wcnt - wb, 8);
    bus_stop();

    // R5 R8 R9 R10 reads
    rsrc[0] = 8'hC3; rsrc[1] = 8'h3C; rsrc[2] = 8'h00;
    rd_txn(8'h07, 3, 1'b0);
    rsrc[0] = 8'hE7; rsrc[1] = 8'h81;
    rd_txn(8'h10, 2, 1'b1);
    rsrc[0] = 8'h00; rsrc[1] = 8'hFF; rsrc[2] = 8'h55; rsrc[3] = 8'hAA;
    rd_txn(8'h11, 4, 1'b1);
    rsrc[0] = 8'h80;
    rd_txn(8'h00, 1, 1'b1);

    // R11 timeout enabled: stall drops the transaction
    ten = 1'b1;
    wb = wcnt;
    bus_start();
    send_byte(8'h98, a);
    chk(a, "R11 address ack before stall", a, 1);
    cyc(TO + 100);
    chk(sda_oe == 1'b0, "R11 released after timeout", sda_oe, 0);
    send_byte(8'h22, a);
    chk(!a && wcnt == wb, "R11 byte ignored after timeout", wcnt - wb, 0);
    bus_stop();
    ten = 1'b0;

    // R11 timeout disabled: the same stall has no effect
    wb = wcnt;
    bus_start();
    send_byte(8'h98, a);
    cyc(TO + 100);
    send_byte(8'h22, a);
    chk(a && wcnt - wb == 1, "R11 stall ignored when disabled", wcnt - wb, 1);
    chk(wlog[8'(wb)] == 8'h22, "R11 byte after stall", wlog[8'(wb)], 8'h22);
    bus_stop();

    cyc(4);
    chk(bad12 == 0, "R12 strobe exclusivity and width", bad12, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule